// File: doc/BRIEF.md
# Storage Port Control and Interrupt Register Block

This block is the per-port register file of a storage host controller. It sits on a simple 32-bit memory-mapped bus with one-cycle write and read strobes. It holds the port's control bits, the latched engine events and the interrupt enables, and it drives one interrupt line. Control bits and enables are never written directly. Each is changed through a pair of addresses: one sets the bits written as one, the other clears them.

The port engine reports events as single-cycle pulses, and each pulse is latched. Software sees the latched events twice in one status word. The upper half holds the raw events. The lower half holds the events ANDed with their enables. A control bit selects how software acknowledges events. When that bit is one, software writes ones to the status word to clear bits. When it is zero, reading the status word clears it.

The device-reset control bit clears itself after a programmable number of cycles. The port-reset bit stays set until software clears it, and while it is set the interrupt line is held low.

Top module: `port_ctl_regs`

## Requirements
- R1: After reset the control word holds only bit 0 (port reset) as one, the enable register (offset 0x10) reads zero, the status word (offset 0x08) reads zero and `irq` is low.
- R2: A write to offset 0x00 sets, and a write to offset 0x04 clears, every implemented control bit written as one. The implemented bits are 0 port reset, 1 device reset, 2 port initialize, 3 write-one-to-clear enable, 6 resume, 10 32-bit activation and 13 multiplier enable. All other bits read zero and cannot be set.
- R3: A read of offset 0x00 returns the control bits, with bit 31 set only when `port_ready` is high and neither port reset nor device reset is set.
- R4: Port reset (bit 0) stays set until a write to offset 0x04 with bit 0 set.
- R5: Device reset (bit 1), once set, reads as one for exactly DRST_CYC consecutive cycles and then clears itself. The default is 16.
- R6: Event input bit i is latched: 0 command complete, 1 command error, 2 port-ready change, 3 power change, 4 PHY-ready change, 5 COMWAKE, 6 unknown FIS, 11 SDB FIS, others spare. The status word at 0x08 shows event i raw at bit 16+i. Bits 10:0 show the events ANDed with the enables. All other status bits read zero.
- R7: A write to 0x10 sets, and a write to 0x14 clears, the enable bits 11:0 and the steering field 31:30 written as one. A read of 0x10 returns both.
- R8: With bit 3 set, a write to 0x08 clears latched event i when data bit i or bit 16+i is one. Writing 0x0FFF0FFF clears all events.
- R9: With bit 3 clear, writes to 0x08 leave the events unchanged. A read of 0x08 returns the events and then clears all of them.
- R10: An event pulse in the same cycle as a clear of that bit leaves the bit set.
- R11: `irq` is a register. It is high one cycle after any of status bits 10:0 is one while port reset is clear.
- R12: Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | NEV | Single-cycle event pulses from the port engine |
| port_ready | input | 1 | Engine can accept commands |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `evt_in` bits are one-cycle pulses and that the bus never asserts `bus_wr` and `bus_rd` in the same cycle. The write-ignore check depends on that second assumption. The stimulus uses tasks that drive exactly one strobe per access and drop every event bit after a single edge. Only the collision test lines up an event with a write in the same cycle.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int DW        = 32;
  localparam int OFS_CSET  = 'h00;
  localparam int OFS_CCLR  = 'h04;
  localparam int OFS_STAT  = 'h08;
  localparam int OFS_ESET  = 'h10;
  localparam int OFS_ECLR  = 'h14;
  localparam int CB_PRST   = 0;
  localparam int CB_DRST   = 1;
  localparam int CB_W1C    = 3;
  localparam int RDY_BIT   = 31;
  localparam int RAW_SHIFT = 16;
  localparam int STEER_LSB = 30;
  // implemented control bits: 0,1,2,3,6,10,13
  localparam logic [DW-1:0] CTRL_IMPL = 32'h0000_244F;
endpackage

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
  import ptc_pkg::*;
#(
  parameter int DRST_CYC = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q
);
  localparam int CNT_W = $clog2(DRST_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    ctrl_d;
  logic             drst_load;

  assign drst_load = set_we && wdata[CB_DRST];

  always_comb begin
    ctrl_d = ctrl_q;
    cnt_d  = cnt_q;
    if (set_we) ctrl_d = ctrl_d | (wdata & CTRL_IMPL);
    if (clr_we) ctrl_d = ctrl_d & ~(wdata & CTRL_IMPL);
    if (drst_load) begin
      cnt_d = CNT_W'(DRST_CYC - 1);
    end else if (ctrl_q[CB_DRST]) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      else             ctrl_d[CB_DRST] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= DW'(1) << CB_PRST;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/ptc_events.sv
module ptc_events #(
  parameter int NEV = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] evt_in,
  input  logic [NEV-1:0] clr_vec,
  input  logic           en_set_we,
  input  logic           en_clr_we,
  input  logic [NEV-1:0] en_wdata,
  input  logic [1:0]     steer_wdata,
  output logic [NEV-1:0] evt_q,
  output logic [NEV-1:0] en_q,
  output logic [1:0]     steer_q
);
  // one latch per event; a pulse overrides a clear in the same cycle
  for (genvar i = 0; i < NEV; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst) evt_q[i] <= 1'b0;
      else     evt_q[i] <= evt_in[i] | (evt_q[i] & ~clr_vec[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      steer_q <= '0;
    end else if (en_set_we) begin
      en_q    <= en_q | en_wdata;
      steer_q <= steer_q | steer_wdata;
    end else if (en_clr_we) begin
      en_q    <= en_q & ~en_wdata;
      steer_q <= steer_q & ~steer_wdata;
    end
  end
endmodule

// File: rtl/port_ctl_regs.sv
module port_ctl_regs
  import ptc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NEV      = 12,
  parameter int NMASK    = 11,
  parameter int DRST_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NEV-1:0]    evt_in,
  input  logic              port_ready,
  output logic              irq
);
  logic [DW-1:0]    ctrl_q;
  logic [NEV-1:0]   evt_q, en_q, clr_vec;
  logic [1:0]       steer_q;
  logic [NMASK-1:0] masked;
  logic [DW-1:0]    stat_word, ctrl_word, en_word;
  logic             hit_cset, hit_cclr, hit_stat, hit_eset, hit_eclr;

  assign hit_cset = bus_addr == ADDR_W'(OFS_CSET);
  assign hit_cclr = bus_addr == ADDR_W'(OFS_CCLR);
  assign hit_stat = bus_addr == ADDR_W'(OFS_STAT);
  assign hit_eset = bus_addr == ADDR_W'(OFS_ESET);
  assign hit_eclr = bus_addr == ADDR_W'(OFS_ECLR);

  ptc_ctrl #(.DRST_CYC(DRST_CYC)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .set_we (bus_wr && hit_cset),
    .clr_we (bus_wr && hit_cclr),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q)
  );

  // clear source depends on acknowledge mode
  always_comb begin
    clr_vec = '0;
    if (ctrl_q[CB_W1C]) begin
      if (bus_wr && hit_stat)
        clr_vec = bus_wdata[NEV-1:0] | bus_wdata[RAW_SHIFT +: NEV];
    end else if (bus_rd && hit_stat) begin
      clr_vec = '1;
    end
  end

  ptc_events #(.NEV(NEV)) u_evt (
    .clk         (clk),
    .rst         (rst),
    .evt_in      (evt_in),
    .clr_vec     (clr_vec),
    .en_set_we   (bus_wr && hit_eset),
    .en_clr_we   (bus_wr && hit_eclr),
    .en_wdata    (bus_wdata[NEV-1:0]),
    .steer_wdata (bus_wdata[STEER_LSB +: 2]),
    .evt_q       (evt_q),
    .en_q        (en_q),
    .steer_q     (steer_q)
  );

  assign masked = evt_q[NMASK-1:0] & en_q[NMASK-1:0];

  always_comb begin
    stat_word = '0;
    stat_word[RAW_SHIFT +: NEV] = evt_q;
    stat_word[NMASK-1:0]        = masked;
    ctrl_word = ctrl_q;
    ctrl_word[RDY_BIT] = port_ready && !ctrl_q[CB_PRST] && !ctrl_q[CB_DRST];
    en_word = '0;
    en_word[NEV-1:0]          = en_q;
    en_word[STEER_LSB +: 2]   = steer_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= (|masked) && !ctrl_q[CB_PRST];
      if (bus_rd) begin
        if (hit_cset)      bus_rdata <= ctrl_word;
        else if (hit_stat) bus_rdata <= stat_word;
        else if (hit_eset) bus_rdata <= en_word;
        else               bus_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int ADDR_W   = 8,
  parameter int NEV      = 12,
  parameter int NMASK    = 11,
  parameter int DRST_CYC = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NEV-1:0]    evt_in,
  input logic [31:0]       ctrl_q,
  input logic [NEV-1:0]    evt_q,
  input logic [NEV-1:0]    en_q,
  input logic              irq
);
  int unsigned drst_run;

  always_ff @(posedge clk) begin
    if (rst)                                           drst_run <= 0;
    else if (bus_wr && bus_addr == 'h00 && bus_wdata[1]) drst_run <= 1;
    else if (ctrl_q[1])                                drst_run <= drst_run + 1;
    else                                               drst_run <= 0;
  end

  assert_drst_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[1] |-> drst_run <= DRST_CYC);

  assert_prst_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[0] && !(bus_wr && bus_addr == 'h04 && bus_wdata[0])) |=> ctrl_q[0]);

  assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (|evt_in) |=> ((evt_q & $past(evt_in)) == $past(evt_in)));

  assert_w1c_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == 'h08 && !ctrl_q[3])
      |=> evt_q == ($past(evt_q) | $past(evt_in)));

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(!ctrl_q[0]) && $past(|(evt_q[NMASK-1:0] & en_q[NMASK-1:0]))));
endmodule

bind port_ctl_regs ptc_checker #(
  .ADDR_W(ADDR_W), .NEV(NEV), .NMASK(NMASK), .DRST_CYC(DRST_CYC)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .evt_in(evt_in), .ctrl_q(ctrl_q), .evt_q(evt_q),
  .en_q(en_q), .irq(irq)
);

// File: tb/sim_port_ctl_regs.sv
`timescale 1ns/1ps
module sim_port_ctl_regs;
  localparam int NEV = 12;
  localparam int DRST = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NEV-1:0] evt_in = '0;
  logic        port_ready = 1'b1;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  port_ctl_regs #(.DRST_CYC(DRST)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .port_ready(port_ready), .irq(irq)
  );

  // {enable, event pulse, expected status}
  localparam logic [95:0] VEC [0:4] = '{
    {32'h0000_0003, 32'h0000_0001, 32'h0001_0001},
    {32'h0000_0000, 32'h0000_0012, 32'h0012_0000},
    {32'h0000_0800, 32'h0000_0800, 32'h0800_0000},
    {32'h0000_07FF, 32'h0000_007F, 32'h007F_007F},
    {32'h0000_0010, 32'h0000_0050, 32'h0050_0010}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [NEV-1:0] v);
    @(negedge clk);
    evt_in = v;
    @(posedge clk); #1;
    evt_in = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state, R3 ready masked by port reset
    rd(8'h00, d); chk("R1 ctrl after reset / R3 ready hidden", d, 32'h0000_0001);
    rd(8'h10, d); chk("R1 enables after reset", d, 32'h0);
    rd(8'h08, d); chk("R1 status after reset", d, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R4 port reset is sticky
    repeat (5) @(posedge clk);
    rd(8'h00, d); chk("R4 port reset held", d, 32'h0000_0001);
    wr(8'h04, 32'h1);
    rd(8'h00, d); chk("R3 ready after port reset cleared", d, 32'h8000_0000);

    // R2 set/clear, unimplemented bits ignored
    wr(8'h00, 32'h0000_FFF8);
    rd(8'h00, d); chk("R2 set implemented bits only", d, 32'h8000_2448);
    wr(8'h04, 32'h0000_2440);
    rd(8'h00, d); chk("R2 clear address", d, 32'h8000_0008);

    // R5 device reset self-clears, R3 ready low meanwhile
    wr(8'h00, 32'h2);
    hi = 0;
    for (int k = 0; k < 100; k++) begin
      rd(8'h00, d);
      if (k == 0) chk("R3 ready low during device reset", d, 32'h0000_000A);
      if (!d[1]) break;
      hi++;
    end
    chk("R5 device reset duration", 32'(hi), 32'(DRST));
    chk("R5 ctrl after self-clear", d, 32'h8000_0008);

    // R6 / R8 / R11 table walk
    for (int i = 0; i < 5; i++) begin
      logic [31:0] en, ev, ex;
      {en, ev, ex} = VEC[i];
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h10, en);
      wr(8'h08, 32'h0FFF_0FFF);
      pulse(ev[NEV-1:0]);
      rd(8'h08, d); chk($sformatf("R6 status vector %0d", i), d, ex);
      chk($sformatf("R11 irq vector %0d", i), {31'b0, irq}, {31'b0, (ex[10:0] != 0)});
    end
    wr(8'h08, 32'h0FFF_0FFF);
    rd(8'h08, d); chk("R8 clear all", d, 32'h0);

    // R8 selective clear through raw position
    wr(8'h14, 32'hFFFF_FFFF);
    pulse(12'h003);
    wr(8'h08, 32'h0002_0000);
    rd(8'h08, d); chk("R8 selective clear", d, 32'h0001_0000);

    // R10 event beats clear in the same cycle
    wr(8'h08, 32'h0FFF_0FFF);
    @(negedge clk);
    evt_in = 12'h001; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h0001_0001;
    @(posedge clk); #1;
    evt_in = '0; bus_wr = 1'b0;
    rd(8'h08, d); chk("R10 event wins over clear", d, 32'h0001_0000);

    // R7 enable and steering set/clear
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h10, 32'hC000_0005);
    wr(8'h14, 32'h4000_0001);
    rd(8'h10, d); chk("R7 enable/steer", d, 32'h8000_0004);

    // R9 write ignored without W1C, read clears
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0FFF_0FFF);
    wr(8'h04, 32'h8);
    pulse(12'h004);
    wr(8'h08, 32'h0FFF_0FFF);
    rd(8'h08, d); chk("R9 write ignored", d, 32'h0004_0000);
    rd(8'h08, d); chk("R9 read cleared", d, 32'h0);

    // R11 irq gated by port reset
    wr(8'h10, 32'h1);
    pulse(12'h001);
    rd(8'h00, d); chk("R11 irq raised", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h1);
    rd(8'h00, d); chk("R11 irq masked by port reset", {31'b0, irq}, 32'h0);

    // R12 unmapped read
    rd(8'h20, d); chk("R12 unmapped read", d, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule